// File: doc/BRIEF.md
# Odd-Address Fault Detector with Deferred Raise

This block sits beside a processor's memory access path. It examines every access the core issues: instruction fetches, operand reads, released operand writes and branch targets. An access that touches a word or a long word at an odd byte address has an alignment fault. The block then decides in which cycle that fault becomes a visible address-error request. The request is not raised when the access is issued. Each kind of access has its own trigger.

- A fetch fault is raised right away.
- A read fault waits until the core consumes the returned data.
- A released write fault waits for the next instruction boundary or the next operand access, whichever comes first.
- A branch-target fault waits until the program counter is actually loaded with the target. A branch that is not taken is forgotten.

The deferred faults share one holding slot. A flush input empties that slot. When a request is raised, the block presents four fields for the exception sequencer:

- the faulting address,
- the return PC,
- the PC of the instruction that caused the fault,
- the kind of access.

Top module: `oafd_top`

## Requirements
- R1: A fault exists when the address LSB is 1 and the access is a fetch (any size) or a read, write or branch whose size code is not byte. Access kind codes on `acc_kind` are 00 fetch, 01 read, 10 write, 11 branch. Size codes on `acc_size` are 00 byte, 01 word, 10 long, 11 treated as long.
- R2: A faulting fetch raises `ae_req` on the clock edge that samples it. The reported fields are fault address = access address, return PC = current PC = `acc_pc`, and `ae_kind` = 00.
- R3: A faulting read raises `ae_req` only on the edge that samples `use_data` while the read is held. The reported fields are address = read address, return PC = current PC = `acc_pc` at issue, and `ae_kind` = 01.
- R4: A faulting released write is raised on the edge that first samples either `insn_bound` or a new read or write access while the write is held. It is reported with `ae_kind` = 10.
- R5: A faulting branch is raised on the edge that samples `pc_upd` with `br_taken` high. If `pc_upd` is sampled with `br_taken` low, the held branch fault is discarded and never raised.
- R6: For a branch fault, the fault address and the return PC both equal the odd target, the current PC is the branch instruction's `acc_pc`, and `ae_kind` = 11.
- R7: At most one deferred fault is held. A faulting read, write or branch arriving while the slot is occupied, including in the cycle the slot is released, is ignored and never raised.
- R8: `flush` discards a held fault. In the same cycle it overrides any trigger, so no request is raised.
- R9: When a held fault is raised in the same cycle that a faulting fetch is presented, the held fault is reported and the fetch fault is dropped.
- R10: After reset `ae_req` is 0 and the slot is empty. `ae_req` is high for exactly the cycles that follow a raising edge; no fault means no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access descriptor is present this cycle |
| acc_kind | input | 2 | Access kind: 00 fetch, 01 read, 10 write, 11 branch |
| acc_size | input | 2 | Access size: 00 byte, 01 word, 10/11 long |
| acc_addr | input | AW | Access address or branch target |
| acc_pc | input | AW | PC of the instruction issuing the access |
| use_data | input | 1 | The core consumes the data of the held read |
| insn_bound | input | 1 | Instruction boundary |
| pc_upd | input | 1 | Branch resolution: the PC update point |
| br_taken | input | 1 | Qualifies `pc_upd`: the branch is taken |
| flush | input | 1 | Discard any held deferred fault |
| ae_req | output | 1 | Address-error request, one cycle per raised fault |
| ae_kind | output | 2 | Kind of the access that faulted |
| ae_fault_addr | output | AW | Faulting address |
| ae_ret_pc | output | AW | Return PC to be stacked |
| ae_cur_pc | output | AW | PC of the faulting instruction |

## Verification
The bench targets the places where a deferral rule can go wrong:

- **Byte accesses at odd addresses.** A design that ignored size would raise on these.
- **Write triggers.** A held write must fire on a following operand access as well as on a boundary. A design that only watched boundaries would report late or never.
- **Untaken branches.** A design that failed to drop the branch on a not-taken update would raise a spurious error at the next taken update.
- **Collision cases.** These cover a second fault while the slot is full, a flush in the same cycle as a trigger, and a fetch fault colliding with a deferred raise. Each shows up as a wrong address in the report or as a request that should never appear.

A random phase compares every cycle against a behavioural model.

// File: rtl/oafd_pkg.sv
package oafd_pkg;

  typedef enum logic [1:0] {
    K_FETCH  = 2'b00,
    K_READ   = 2'b01,
    K_WRITE  = 2'b10,
    K_BRANCH = 2'b11
  } acc_kind_e;

  typedef enum logic [1:0] {
    S_BYTE = 2'b00,
    S_WORD = 2'b01,
    S_LONG = 2'b10,
    S_LONG_ALT = 2'b11
  } acc_size_e;

  // Misalignment rule: fetches are always word-sized, others fault unless byte.
  function automatic logic misaligned(acc_kind_e kind, acc_size_e size, logic lsb);
    logic wide;
    wide = (kind == K_FETCH) || (size != S_BYTE);
    return wide && lsb;
  endfunction

  // Read or write data access (the kinds that release a held write).
  function automatic logic is_operand(acc_kind_e kind);
    return (kind == K_READ) || (kind == K_WRITE);
  endfunction

  // Whether a held fault of this kind reaches its raise point this cycle.
  function automatic logic trigger_hit(acc_kind_e held, logic use_data,
                                       logic bound, logic opnd_now,
                                       logic pc_upd, logic taken);
    logic hit;
    case (held)
      K_READ:   hit = use_data;
      K_WRITE:  hit = bound || opnd_now;
      K_BRANCH: hit = pc_upd && taken;
      default:  hit = 1'b0;
    endcase
    return hit;
  endfunction

  // Whether a held fault is abandoned without a raise this cycle.
  function automatic logic discard_hit(acc_kind_e held, logic flush,
                                       logic pc_upd, logic taken);
    return flush || ((held == K_BRANCH) && pc_upd && !taken);
  endfunction

endpackage

// File: rtl/oafd_classify.sv
module oafd_classify
  import oafd_pkg::*;
(
  input  logic      acc_valid,
  input  acc_kind_e kind,
  input  acc_size_e size,
  input  logic      addr_lsb,
  output logic      flt_det,
  output logic      fetch_flt,
  output logic      defer_flt,
  output logic      opnd_acc
);

  always_comb begin
    flt_det   = acc_valid && misaligned(kind, size, addr_lsb);
    fetch_flt = flt_det && (kind == K_FETCH);
    defer_flt = flt_det && (kind != K_FETCH);
    opnd_acc  = acc_valid && is_operand(kind);
  end

endmodule

// File: rtl/oafd_slot.sv
module oafd_slot
  import oafd_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_req,
  input  acc_kind_e     cap_kind,
  input  logic [AW-1:0] cap_addr,
  input  logic [AW-1:0] cap_pc,
  input  logic          use_data,
  input  logic          insn_bound,
  input  logic          opnd_acc,
  input  logic          pc_upd,
  input  logic          br_taken,
  input  logic          flush,
  output logic          pend_vld,
  output acc_kind_e     pend_kind,
  output logic [AW-1:0] pend_addr,
  output logic [AW-1:0] pend_pc,
  output logic          fire,
  output logic          drop,
  output logic          cap_take
);

  logic hit_now;
  logic gone_now;

  always_comb begin
    hit_now  = trigger_hit(pend_kind, use_data, insn_bound, opnd_acc,
                           pc_upd, br_taken);
    gone_now = discard_hit(pend_kind, flush, pc_upd, br_taken);
    fire     = pend_vld && hit_now && !flush;
    drop     = pend_vld && gone_now;
    cap_take = cap_req && !pend_vld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vld  <= 1'b0;
      pend_kind <= K_FETCH;
      pend_addr <= '0;
      pend_pc   <= '0;
    end else if (fire || drop) begin
      pend_vld <= 1'b0;
    end else if (cap_take) begin
      pend_vld  <= 1'b1;
      pend_kind <= cap_kind;
      pend_addr <= cap_addr;
      pend_pc   <= cap_pc;
    end
  end

endmodule

// File: rtl/oafd_report.sv
module oafd_report
  import oafd_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  acc_kind_e     pend_kind,
  input  logic [AW-1:0] pend_addr,
  input  logic [AW-1:0] pend_pc,
  input  logic          fetch_flt,
  input  logic [AW-1:0] acc_addr,
  input  logic [AW-1:0] acc_pc,
  output logic          ae_req,
  output acc_kind_e     ae_kind,
  output logic [AW-1:0] ae_fault_addr,
  output logic [AW-1:0] ae_ret_pc,
  output logic [AW-1:0] ae_cur_pc
);

  // Branch faults resume at the odd target itself; others at the issuing PC.
  function automatic logic [AW-1:0] resume_pc(acc_kind_e k, logic [AW-1:0] a,
                                              logic [AW-1:0] pc);
    return (k == K_BRANCH) ? a : pc;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ae_req        <= 1'b0;
      ae_kind       <= K_FETCH;
      ae_fault_addr <= '0;
      ae_ret_pc     <= '0;
      ae_cur_pc     <= '0;
    end else if (fire) begin
      ae_req        <= 1'b1;
      ae_kind       <= pend_kind;
      ae_fault_addr <= pend_addr;
      ae_ret_pc     <= resume_pc(pend_kind, pend_addr, pend_pc);
      ae_cur_pc     <= pend_pc;
    end else if (fetch_flt) begin
      ae_req        <= 1'b1;
      ae_kind       <= K_FETCH;
      ae_fault_addr <= acc_addr;
      ae_ret_pc     <= acc_pc;
      ae_cur_pc     <= acc_pc;
    end else begin
      ae_req <= 1'b0;
    end
  end

endmodule

// File: rtl/oafd_top.sv
module oafd_top
  import oafd_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic [1:0]    acc_kind,
  input  logic [1:0]    acc_size,
  input  logic [AW-1:0] acc_addr,
  input  logic [AW-1:0] acc_pc,
  input  logic          use_data,
  input  logic          insn_bound,
  input  logic          pc_upd,
  input  logic          br_taken,
  input  logic          flush,
  output logic          ae_req,
  output logic [1:0]    ae_kind,
  output logic [AW-1:0] ae_fault_addr,
  output logic [AW-1:0] ae_ret_pc,
  output logic [AW-1:0] ae_cur_pc
);

  acc_kind_e     kind_in;
  acc_size_e     size_in;
  logic          flt_det;
  logic          fetch_flt;
  logic          defer_flt;
  logic          opnd_acc;
  logic          pend_vld;
  acc_kind_e     pend_kind;
  logic [AW-1:0] pend_addr;
  logic [AW-1:0] pend_pc;
  logic          fire;
  logic          drop;
  logic          cap_take;
  acc_kind_e     rep_kind;

  assign kind_in = acc_kind_e'(acc_kind);
  assign size_in = acc_size_e'(acc_size);

  oafd_classify u_cls (
    .acc_valid (acc_valid),
    .kind      (kind_in),
    .size      (size_in),
    .addr_lsb  (acc_addr[0]),
    .flt_det   (flt_det),
    .fetch_flt (fetch_flt),
    .defer_flt (defer_flt),
    .opnd_acc  (opnd_acc)
  );

  oafd_slot #(.AW(AW)) u_slot (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_req    (defer_flt),
    .cap_kind   (kind_in),
    .cap_addr   (acc_addr),
    .cap_pc     (acc_pc),
    .use_data   (use_data),
    .insn_bound (insn_bound),
    .opnd_acc   (opnd_acc),
    .pc_upd     (pc_upd),
    .br_taken   (br_taken),
    .flush      (flush),
    .pend_vld   (pend_vld),
    .pend_kind  (pend_kind),
    .pend_addr  (pend_addr),
    .pend_pc    (pend_pc),
    .fire       (fire),
    .drop       (drop),
    .cap_take   (cap_take)
  );

  oafd_report #(.AW(AW)) u_rep (
    .clk           (clk),
    .rst_n         (rst_n),
    .fire          (fire),
    .pend_kind     (pend_kind),
    .pend_addr     (pend_addr),
    .pend_pc       (pend_pc),
    .fetch_flt     (fetch_flt),
    .acc_addr      (acc_addr),
    .acc_pc        (acc_pc),
    .ae_req        (ae_req),
    .ae_kind       (rep_kind),
    .ae_fault_addr (ae_fault_addr),
    .ae_ret_pc     (ae_ret_pc),
    .ae_cur_pc     (ae_cur_pc)
  );

  assign ae_kind = rep_kind;

endmodule

// File: rtl/oafd_chk.sv
module oafd_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_valid,
  input logic [1:0]    acc_kind,
  input logic [1:0]    acc_size,
  input logic [AW-1:0] acc_addr,
  input logic          use_data,
  input logic          insn_bound,
  input logic          pc_upd,
  input logic          br_taken,
  input logic          flush,
  input logic          flt_det,
  input logic          fetch_flt,
  input logic          pend_vld,
  input logic [1:0]    pend_kind,
  input logic [AW-1:0] pend_addr,
  input logic          fire,
  input logic          drop,
  input logic          ae_req,
  input logic [1:0]    ae_kind,
  input logic [AW-1:0] ae_fault_addr,
  input logic [AW-1:0] ae_ret_pc
);

  AST_BYTE_NEVER_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_kind != 2'b00 && acc_size == 2'b00) |-> !flt_det); // R1

  AST_FETCH_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_kind == 2'b00 && acc_addr[0] && !fire) |=>
      (ae_req && ae_kind == 2'b00 && ae_fault_addr == $past(acc_addr))); // R2

  AST_READ_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_vld && pend_kind == 2'b01 && !use_data) |=>
      !(ae_req && ae_kind == 2'b01)); // R3

  AST_WRITE_AT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_vld && pend_kind == 2'b10 && insn_bound && !flush) |=>
      (ae_req && ae_kind == 2'b10)); // R4

  AST_UNTAKEN_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_vld && pend_kind == 2'b11 && pc_upd && !br_taken) |=>
      (!pend_vld && !(ae_req && ae_kind == 2'b11))); // R5

  AST_BRANCH_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ae_req && ae_kind == 2'b11) |-> (ae_ret_pc == ae_fault_addr)); // R6

  AST_SLOT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_vld && !fire && !drop) |=> (pend_vld && $stable(pend_addr))); // R7

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && pend_vld) |=> (!pend_vld && !(ae_req && ae_kind != 2'b00))); // R8

  AST_HELD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && fetch_flt) |=> (ae_req && ae_kind != 2'b00)); // R9

  AST_QUIET_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && !fetch_flt) |=> !ae_req); // R10

endmodule

bind oafd_top oafd_chk #(.AW(AW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .acc_valid     (acc_valid),
  .acc_kind      (acc_kind),
  .acc_size      (acc_size),
  .acc_addr      (acc_addr),
  .use_data      (use_data),
  .insn_bound    (insn_bound),
  .pc_upd        (pc_upd),
  .br_taken      (br_taken),
  .flush         (flush),
  .flt_det       (flt_det),
  .fetch_flt     (fetch_flt),
  .pend_vld      (pend_vld),
  .pend_kind     (pend_kind),
  .pend_addr     (pend_addr),
  .fire          (fire),
  .drop          (drop),
  .ae_req        (ae_req),
  .ae_kind       (ae_kind),
  .ae_fault_addr (ae_fault_addr),
  .ae_ret_pc     (ae_ret_pc)
);

// File: tb/tb_oafd_top.sv
module tb_oafd_top;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          acc_valid = 1'b0;
  logic [1:0]    acc_kind = 2'b00;
  logic [1:0]    acc_size = 2'b00;
  logic [AW-1:0] acc_addr = '0;
  logic [AW-1:0] acc_pc = '0;
  logic          use_data = 1'b0;
  logic          insn_bound = 1'b0;
  logic          pc_upd = 1'b0;
  logic          br_taken = 1'b0;
  logic          flush = 1'b0;
  logic          ae_req;
  logic [1:0]    ae_kind;
  logic [AW-1:0] ae_fault_addr;
  logic [AW-1:0] ae_ret_pc;
  logic [AW-1:0] ae_cur_pc;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  oafd_top #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_kind(acc_kind),
    .acc_size(acc_size), .acc_addr(acc_addr), .acc_pc(acc_pc),
    .use_data(use_data), .insn_bound(insn_bound), .pc_upd(pc_upd),
    .br_taken(br_taken), .flush(flush), .ae_req(ae_req), .ae_kind(ae_kind),
    .ae_fault_addr(ae_fault_addr), .ae_ret_pc(ae_ret_pc), .ae_cur_pc(ae_cur_pc)
  );

  // Behavioural reference: a queue of at most one waiting fault.
  int unsigned q_kind[$];
  int unsigned q_addr[$];
  int unsigned q_pc[$];
  bit          m_req = 0;
  int unsigned m_kind = 0, m_addr = 0, m_ret = 0, m_cur = 0;

  function automatic bit ref_bad_align(int unsigned k, int unsigned s, int unsigned a);
    if (a % 2 == 0) return 0;
    if (k == 0) return 1;
    return s != 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q_kind.delete(); q_addr.delete(); q_pc.delete();
      m_req = 0; m_kind = 0; m_addr = 0; m_ret = 0; m_cur = 0;
    end else begin
      bit raise_q, toss_q, f_now, d_now;
      raise_q = 0; toss_q = 0;
      f_now = acc_valid && ref_bad_align(acc_kind, acc_size, acc_addr) && acc_kind == 0;
      d_now = acc_valid && ref_bad_align(acc_kind, acc_size, acc_addr) && acc_kind != 0;
      if (q_kind.size() > 0) begin
        if (flush) toss_q = 1;
        else if (q_kind[0] == 1 && use_data) raise_q = 1;
        else if (q_kind[0] == 2 && (insn_bound ||
                 (acc_valid && (acc_kind == 1 || acc_kind == 2)))) raise_q = 1;
        else if (q_kind[0] == 3 && pc_upd) begin
          if (br_taken) raise_q = 1; else toss_q = 1;
        end
      end
      if (raise_q) begin
        m_req = 1; m_kind = q_kind[0]; m_addr = q_addr[0]; m_cur = q_pc[0];
        m_ret = (q_kind[0] == 3) ? q_addr[0] : q_pc[0];
      end else if (f_now) begin
        m_req = 1; m_kind = 0; m_addr = acc_addr; m_ret = acc_pc; m_cur = acc_pc;
      end else m_req = 0;
      if (raise_q || toss_q) begin
        void'(q_kind.pop_front()); void'(q_addr.pop_front()); void'(q_pc.pop_front());
      end else if (d_now && q_kind.size() == 0) begin
        q_kind.push_back(acc_kind); q_addr.push_back(acc_addr); q_pc.push_back(acc_pc);
      end
    end
  end

  function automatic string req_of(int unsigned k);
    case (k)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R6";
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      total++;
      if (ae_req !== m_req) begin
        bad++;
        $display("FAIL model R10 ae_req act=%0b exp=%0b", ae_req, m_req);
      end else if (m_req) begin
        if (ae_kind !== m_kind[1:0] || ae_fault_addr !== m_addr ||
            ae_ret_pc !== m_ret || ae_cur_pc !== m_cur) begin
          bad++;
          $display("FAIL model %s act=%0d/%h/%h/%h exp=%0d/%h/%h/%h", req_of(m_kind),
                   ae_kind, ae_fault_addr, ae_ret_pc, ae_cur_pc,
                   m_kind, m_addr, m_ret, m_cur);
        end
      end
    end
  end

  task automatic cyc(input bit v, input int k, input int s, input int unsigned a,
                     input int unsigned pc, input bit u, input bit b,
                     input bit p, input bit t, input bit f);
    acc_valid = v; acc_kind = k[1:0]; acc_size = s[1:0];
    acc_addr = a; acc_pc = pc; use_data = u; insn_bound = b;
    pc_upd = p; br_taken = t; flush = f;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic chk(input string req, input bit exp_req, input int exp_kind,
                     input int unsigned exp_addr, input int unsigned exp_ret,
                     input int unsigned exp_cur);
    bit ok;
    total++;
    ok = (ae_req === exp_req);
    if (exp_req)
      ok = ok && ae_kind === exp_kind[1:0] && ae_fault_addr === exp_addr &&
           ae_ret_pc === exp_ret && ae_cur_pc === exp_cur;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0b/%0d/%h/%h/%h exp=%0b/%0d/%h/%h/%h", req,
               ae_req, ae_kind, ae_fault_addr, ae_ret_pc, ae_cur_pc,
               exp_req, exp_kind, exp_addr, exp_ret, exp_cur);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog R10 act=timeout exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset", 0, 0, 0, 0, 0);
    rst_n = 1'b1;
    idle();
    chk("R10 idle", 0, 0, 0, 0, 0);

    // R2 fetch raised at once
    cyc(1, 0, 1, 32'h1001, 32'h1000, 0, 0, 0, 0, 0);
    chk("R2 fetch", 1, 0, 32'h1001, 32'h1000, 32'h1000);
    idle();
    chk("R10 pulse", 0, 0, 0, 0, 0);

    // R1 byte read odd never faults, long read even never faults
    cyc(1, 1, 0, 32'h2001, 32'h200, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    chk("R1 byte", 0, 0, 0, 0, 0);
    cyc(1, 1, 2, 32'h2002, 32'h204, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    chk("R1 even", 0, 0, 0, 0, 0);

    // R3 read waits for consumption
    cyc(1, 1, 2, 32'h3003, 32'h300, 0, 0, 0, 0, 0);
    chk("R3 issue", 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    chk("R3 wait", 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    chk("R3 use", 1, 1, 32'h3003, 32'h300, 32'h300);

    // R4 write released at boundary, then at the next operand access
    cyc(1, 2, 1, 32'h4005, 32'h400, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    chk("R4 wait", 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    chk("R4 bound", 1, 2, 32'h4005, 32'h400, 32'h400);
    cyc(1, 2, 2, 32'h4007, 32'h404, 0, 0, 0, 0, 0);
    cyc(1, 1, 0, 32'h4010, 32'h408, 0, 0, 0, 0, 0);
    chk("R4 access", 1, 2, 32'h4007, 32'h404, 32'h404);

    // R5 R6 branch taken
    cyc(1, 3, 1, 32'h5009, 32'h500, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 1, 0, 0, 0);
    chk("R5 wait", 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 1, 0);
    chk("R6 fields", 1, 3, 32'h5009, 32'h5009, 32'h500);
    // R5 not taken drops
    cyc(1, 3, 1, 32'h6001, 32'h600, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    chk("R5 untaken", 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 1, 0);
    chk("R5 gone", 0, 0, 0, 0, 0);

    // R7 second fault ignored while slot busy
    cyc(1, 1, 1, 32'h7001, 32'h700, 0, 0, 0, 0, 0);
    cyc(1, 2, 1, 32'h7003, 32'h704, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    chk("R7 first", 1, 1, 32'h7001, 32'h700, 32'h700);
    cyc(0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    chk("R7 ignored", 0, 0, 0, 0, 0);

    // R8 flush beats trigger
    cyc(1, 1, 1, 32'h8001, 32'h800, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 0, 1);
    chk("R8 flush", 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    chk("R8 empty", 0, 0, 0, 0, 0);

    // R9 held raise beats fetch fault
    cyc(1, 1, 1, 32'h9001, 32'h900, 0, 0, 0, 0, 0);
    cyc(1, 0, 1, 32'hA001, 32'hA00, 1, 0, 0, 0, 0);
    chk("R9 held", 1, 1, 32'h9001, 32'h900, 32'h900);
    idle();
    chk("R9 dropped", 0, 0, 0, 0, 0);

    // random traffic compared with the model every cycle
    for (int i = 0; i < 2000; i++) begin
      int r;
      r = $urandom % 16;
      cyc($urandom % 3 == 0, $urandom % 4, $urandom % 4, $urandom % 64,
          ($urandom % 16) * 4, r == 1, r == 2, r == 3 || r == 4, r == 3,
          ($urandom % 29) == 0);
    end
    idle();

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule